// File: doc/BRIEF.md
# Two-Stage Watchdog with Reset Gate

This block is a software-serviced watchdog for a system controller. A 10-bit down-counter is advanced by a tick-enable pulse (one tick is meant to be roughly 0.6 s of system time). Software sets a timeout in ticks, releases or freezes the counter through a halt bit, and services the watchdog by writing any value to a reload register. The first time the counter runs out, the block records a status flag and starts a second countdown of the same length. If that second countdown also runs out before software clears the flag, the block asks for a system reset, unless a no-reboot control bit is set, in which case only the status bits change.

Software reaches the block through a simple synchronous register port: a write strobe, a 3-bit register address, 16-bit write data and a combinational read-data bus. An interrupt output, enabled by its own control bit, lets the first expiry notify a handler on systems where the reset path is blocked.

Top module: `wdog_dual`

## Requirements
- R1: After reset the control register (address 0) reads 3 (halt bit 0 set, no-reboot bit 1 set, interrupt-enable bit 2 clear), the status register (address 4) reads 0, the timer register (address 1) reads the default timeout of 16 with upper bits 0, the count (address 5) reads 16, and the reset, interrupt and error outputs are low.
- R2: A write to address 2 loads data bits [9:0] as the timeout only when the value lies from 4 to 1021 inclusive; any other value leaves the timeout unchanged and raises `cfg_err` for exactly the one cycle after the write edge.
- R3: A write to address 1 stores data bits [15:10] and leaves the timeout alone; a write to address 2 never changes bits [15:10]. Addresses 1 and 2 both read as {bits [15:10], timeout}.
- R4: A write of any data to address 3 loads the counter with the current timeout, whether or not the counter is halted.
- R5: While the halt bit is clear, each tick lowers the count by one; a tick that finds the count at 0 is an expiry. While halt is set the count does not move.
- R6: An expiry while status bit 0 is clear sets status bit 0 and reloads the counter with the timeout, so the next expiry comes timeout+1 ticks later.
- R7: An expiry while status bit 0 is set sets status bit 2, reloads the counter and sets the halt bit; if the no-reboot bit is clear it also sets status bit 1 and drives `rst_req` high for exactly one cycle, beginning the cycle after the expiry edge.
- R8: With the no-reboot bit set, the second expiry still sets status bit 2 and the halt bit but leaves `rst_req` low and status bit 1 clear.
- R9: Writing a 1 to a status bit position clears that bit; writing 0 leaves it. Clearing bit 0 between expiries makes the next expiry a first expiry again.
- R10: `irq` is high exactly while status bit 0, interrupt-enable and no-reboot are all set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable, one pulse per tick |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Interrupt request on first expiry when resets are blocked |
| cfg_err | output | 1 | One-cycle flag for a rejected timeout write |

## Verification
A wrong count shows at the count register at once and as a shifted expiry, which moves the status change by a whole number of ticks; the bench therefore reads the count at the tick just before an expiry and the status on the expiry tick itself. A wrong first-stage flag turns a first expiry into a second one, so a reset pulse or status bit 2 appears one full timeout early, visible on the cycle after that tick. A stuck no-reboot gate or pulse register shows on `rst_req` in the cycle right after the second expiry, and a halt that fails to set shows when further ticks keep moving the count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int unsigned DW  = 16;
    localparam int unsigned AW  = 3;
    localparam int unsigned TW  = 10;
    localparam int unsigned SPW = DW - TW;

    typedef enum logic [AW-1:0] {
        A_CTRL  = 3'd0,
        A_TIMER = 3'd1,
        A_TMO   = 3'd2,
        A_KICK  = 3'd3,
        A_STAT  = 3'd4,
        A_COUNT = 3'd5
    } addr_e;

    // bit 0 halt, bit 1 no_reboot, bit 2 irq_en
    typedef struct packed {
        logic irq_en;
        logic no_reboot;
        logic halt;
    } ctrl_t;

    // bit 0 first, bit 1 boot, bit 2 second
    typedef struct packed {
        logic second;
        logic boot;
        logic first;
    } stat_t;

    function automatic logic tmo_legal(input logic [TW-1:0] v,
                                       input int unsigned lo,
                                       input int unsigned hi);
        return (32'(v) >= lo) && (32'(v) <= hi);
    endfunction
endpackage

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
#(
    parameter int unsigned TMO_INIT = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          halt,
    input  logic          load,
    input  logic [TW-1:0] tmo,
    output logic [TW-1:0] cnt,
    output logic          expire
);
    localparam logic [TW-1:0] INIT_V = TW'(TMO_INIT);

    assign expire = tick && !halt && !load && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= INIT_V;
        else if (load || expire)
            cnt <= tmo;
        else if (tick && !halt)
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned TMO_MIN  = 4,
    parameter int unsigned TMO_MAX  = 1021,
    parameter int unsigned TMO_INIT = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    input  logic           expire,
    input  logic [TW-1:0]  cnt,
    output ctrl_t          ctrl,
    output stat_t          stat,
    output logic [TW-1:0]  tmo,
    output logic [SPW-1:0] spare,
    output logic           load,
    output logic [DW-1:0]  bus_rdata,
    output logic           rst_req,
    output logic           cfg_err,
    output logic           irq
);
    localparam logic [TW-1:0] INIT_V = TW'(TMO_INIT);

    logic       wr_ctrl, wr_timer, wr_tmo, wr_stat, tmo_good;
    logic       exp_first, exp_second;
    logic [2:0] stat_n;

    always_comb begin
        wr_ctrl    = bus_wr && (bus_addr == A_CTRL);
        wr_timer   = bus_wr && (bus_addr == A_TIMER);
        wr_tmo     = bus_wr && (bus_addr == A_TMO);
        wr_stat    = bus_wr && (bus_addr == A_STAT);
        load       = bus_wr && (bus_addr == A_KICK);
        tmo_good   = tmo_legal(bus_wdata[TW-1:0], TMO_MIN, TMO_MAX);
        exp_first  = expire && !stat.first;
        exp_second = expire && stat.first;
        // write-one-to-clear first, then hardware sets win
        stat_n     = stat & ~(bus_wdata[2:0] & {3{wr_stat}});
        stat_n[0]  = stat_n[0] | exp_first;
        stat_n[2]  = stat_n[2] | exp_second;
        stat_n[1]  = stat_n[1] | (exp_second && !ctrl.no_reboot);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '{irq_en: 1'b0, no_reboot: 1'b1, halt: 1'b1};
            stat    <= '0;
            tmo     <= INIT_V;
            spare   <= '0;
            rst_req <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl <= ctrl_t'(bus_wdata[2:0]);
            if (exp_second)
                ctrl.halt <= 1'b1;
            stat <= stat_t'(stat_n);
            if (wr_tmo && tmo_good)
                tmo <= bus_wdata[TW-1:0];
            if (wr_timer)
                spare <= bus_wdata[DW-1:TW];
            rst_req <= exp_second && !ctrl.no_reboot;
            cfg_err <= wr_tmo && !tmo_good;
        end
    end

    assign irq = stat.first && ctrl.irq_en && ctrl.no_reboot;

    always_comb begin
        case (bus_addr)
            A_CTRL:          bus_rdata = {{(DW-3){1'b0}}, ctrl};
            A_TIMER, A_TMO:  bus_rdata = {spare, tmo};
            A_STAT:          bus_rdata = {{(DW-3){1'b0}}, stat};
            A_COUNT:         bus_rdata = {{SPW{1'b0}}, cnt};
            default:         bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_dual.sv
module wdog_dual
    import wdog_pkg::*;
#(
    parameter int unsigned TMO_MIN  = 4,
    parameter int unsigned TMO_MAX  = 1021,
    parameter int unsigned TMO_INIT = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          bus_wr,
    input  logic [2:0]    bus_addr,
    input  logic [15:0]   bus_wdata,
    output logic [15:0]   bus_rdata,
    output logic          rst_req,
    output logic          irq,
    output logic          cfg_err
);
    ctrl_t          ctrl;
    stat_t          stat;
    logic [TW-1:0]  tmo;
    logic [TW-1:0]  cnt;
    logic [SPW-1:0] spare;
    logic           load;
    logic           expire;

    wdog_count #(.TMO_INIT(TMO_INIT)) u_count (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .halt   (ctrl.halt),
        .load   (load),
        .tmo    (tmo),
        .cnt    (cnt),
        .expire (expire)
    );

    wdog_regs #(.TMO_MIN(TMO_MIN), .TMO_MAX(TMO_MAX), .TMO_INIT(TMO_INIT)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .expire    (expire),
        .cnt       (cnt),
        .ctrl      (ctrl),
        .stat      (stat),
        .tmo       (tmo),
        .spare     (spare),
        .load      (load),
        .bus_rdata (bus_rdata),
        .rst_req   (rst_req),
        .cfg_err   (cfg_err),
        .irq       (irq)
    );
endmodule

// File: rtl/wdog_dual_chk.sv
module wdog_dual_chk
    import wdog_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           bus_wr,
    input logic [AW-1:0]  bus_addr,
    input logic [DW-1:0]  bus_wdata,
    input ctrl_t          ctrl,
    input stat_t          stat,
    input logic [TW-1:0]  tmo,
    input logic [TW-1:0]  cnt,
    input logic [SPW-1:0] spare,
    input logic           load,
    input logic           expire,
    input logic           rst_req,
    input logic           cfg_err
);
    assert_rst_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    assert_rst_halts_R7: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> ctrl.halt);

    assert_gate_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> !$past(ctrl.no_reboot));

    assert_halt_freezes_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.halt && !load) |=> $stable(cnt));

    assert_upper_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_TMO) |=> $stable(spare));

    assert_bad_tmo_kept_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> $stable(tmo));

    assert_second_after_first_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.second) |-> $past(stat.first));

    assert_w1c_first_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_STAT && bus_wdata[0] && !expire) |=> !stat.first);
endmodule

bind wdog_dual wdog_dual_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctrl      (ctrl),
    .stat      (stat),
    .tmo       (tmo),
    .cnt       (cnt),
    .spare     (spare),
    .load      (load),
    .expire    (expire),
    .rst_req   (rst_req),
    .cfg_err   (cfg_err)
);

// File: tb/wdog_dual_test.sv
module wdog_dual_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        rst_req, irq, cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wdog_dual uut (
        .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req), .irq(irq), .cfg_err(cfg_err)
    );

    // {write data, accepted}
    localparam logic [16:0] TMO_VEC [8] = '{
        {16'h0003, 1'b0}, {16'h0004, 1'b1}, {16'h03FD, 1'b1}, {16'h03FE, 1'b0},
        {16'hFC64, 1'b1}, {16'h03FF, 1'b0}, {16'h0000, 1'b0}, {16'h0005, 1'b1}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    initial begin
        logic [15:0] v;
        logic [9:0]  m_tmo;
        logic [5:0]  m_spare;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl", v, 16'h0003);
        rd(3'd4, v); chk("R1 status", v, 16'h0000);
        rd(3'd1, v); chk("R1 timer", v, 16'h0010);
        rd(3'd5, v); chk("R1 count", v, 16'h0010);
        chk("R1 outputs", {13'd0, rst_req, irq, cfg_err}, 16'h0000);

        // R5 halted counter does not move
        ticks(3);
        rd(3'd5, v); chk("R5 halted count", v, 16'h0010);

        // R2/R3 timeout table
        m_tmo = 10'd16; m_spare = 6'd0;
        foreach (TMO_VEC[i]) begin
            wr(3'd2, TMO_VEC[i][16:1]);
            chk("R2 cfg_err", {15'd0, cfg_err}, {15'd0, !TMO_VEC[i][0]});
            if (TMO_VEC[i][0]) m_tmo = TMO_VEC[i][10:1];
            rd(3'd2, v); chk("R2 R3 timer", v, {m_spare, m_tmo});
        end
        @(negedge clk);
        chk("R2 cfg_err one cycle", {15'd0, cfg_err}, 16'd0);

        // R3 upper bits
        wr(3'd1, 16'hA800);
        rd(3'd1, v); chk("R3 upper write", v, 16'hA805);
        wr(3'd2, 16'h0004);
        rd(3'd1, v); chk("R3 upper kept", v, 16'hA804);

        // R4 reload while halted
        wr(3'd3, 16'h1234);
        rd(3'd5, v); chk("R4 reload", v, 16'h0004);

        // R5/R6 run, no_reboot clear
        wr(3'd0, 16'h0000);
        ticks(1);
        rd(3'd5, v); chk("R5 decrement", v, 16'h0003);
        ticks(3);
        rd(3'd5, v); chk("R5 at zero", v, 16'h0000);
        rd(3'd4, v); chk("R6 not yet", v, 16'h0000);
        ticks(1);
        rd(3'd4, v); chk("R6 first status", v, 16'h0001);
        rd(3'd5, v); chk("R6 reload", v, 16'h0004);
        chk("R6 no reset", {15'd0, rst_req}, 16'd0);

        // R9 write-one-to-clear
        wr(3'd4, 16'h0000);
        rd(3'd4, v); chk("R9 zero write", v, 16'h0001);
        wr(3'd4, 16'h0001);
        rd(3'd4, v); chk("R9 clear", v, 16'h0000);
        // counter continued through the two writes: 4 -> still 4 (no ticks)
        ticks(5);
        rd(3'd4, v); chk("R9 first again", v, 16'h0001);
        chk("R9 no reset", {15'd0, rst_req}, 16'd0);

        // R7 second expiry with reset
        ticks(4);
        chk("R7 before second", {15'd0, rst_req}, 16'd0);
        ticks(1);
        chk("R7 rst pulse", {15'd0, rst_req}, 16'd1);
        @(negedge clk);
        chk("R7 rst one cycle", {15'd0, rst_req}, 16'd0);
        rd(3'd4, v); chk("R7 status", v, 16'h0007);
        rd(3'd0, v); chk("R7 halt set", v, 16'h0001);
        ticks(2);
        rd(3'd5, v); chk("R7 halted after", v, 16'h0004);

        // R8/R10 reset gated
        wr(3'd4, 16'h0007);
        rd(3'd4, v); chk("R9 clear all", v, 16'h0000);
        wr(3'd0, 16'h0006);
        wr(3'd3, 16'h0000);
        ticks(5);
        chk("R10 irq high", {15'd0, irq}, 16'd1);
        wr(3'd0, 16'h0002);
        chk("R10 irq disabled", {15'd0, irq}, 16'd0);
        wr(3'd0, 16'h0006);
        chk("R10 irq again", {15'd0, irq}, 16'd1);
        ticks(5);
        chk("R8 no reset", {15'd0, rst_req}, 16'd0);
        @(negedge clk);
        chk("R8 no reset later", {15'd0, rst_req}, 16'd0);
        rd(3'd4, v); chk("R8 status", v, 16'h0005);
        rd(3'd0, v); chk("R8 halt set", v, 16'h0007);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule